// File: doc/BRIEF.md
# Differencing Interference Cancellation Stage

This block is one stage of a parallel interference cancellation detector for a synchronous multi-user spread-spectrum uplink. It accepts one soft statistic per user and the hard decisions the previous stage made. From these it takes each user's current hard decision as the sign of its soft value. It then refines every soft value by removing only the interference that the *changed* decisions imply. The interference weights come from a preloaded square matrix of coefficients. The stage presents the refined soft values and its own decisions, with a one-cycle valid strobe, to the next stage.

A change in a decision is always -2, 0 or +2. A cancellation term is therefore the coefficient doubled and then added or subtracted, or nothing at all, so no multiplier is needed. The stage handles one coefficient per clock and visits every off-diagonal entry once. A detection therefore takes a fixed number of cycles. Three copies are chained: soft values feed soft values, decisions feed previous decisions, and valid feeds load. The copy at the head of the chain is built with the `FIRST_STAGE` parameter set. It treats the previous decisions as zero, so it performs full cancellation with terms of plus or minus one coefficient. The coefficient matrix is written once per frame, before the chain runs.

Top module: `pic_diff_stage`

## Requirements
- R1: While `out_valid` is high, each bit of `out_dec` is the sign of the matching accepted input soft value. Bit value 1 means a decision of -1 (negative input). Bit value 0 means +1, and a zero input counts as +1.
- R2: The stage builds a difference value for each user j as current decision minus previous decision, with a previous-decision bit of 1 meaning -1. When `out_valid` is high, user k's output is its input minus the sum over j≠k of coefficient(k,j) times that difference. Coefficient(k,j) is the value written at `coef_row`=k, `coef_col`=j. User k's soft value sits at bits [k*W +: W] of the soft buses.
- R3: Every single term is applied with saturation at the W-bit two's-complement limits (-2048 and 2047 for W=12). Terms are applied in ascending order of j, so the result never wraps.
- R4: A user whose previous decision equals its current decision contributes nothing. If every previous decision matches, each output soft value equals its input.
- R5: With `FIRST_STAGE`=1, `in_prev_dec` has no effect. Each difference value is the current decision itself (±1), so the stage performs full cancellation.
- R6: The diagonal coefficients (row equal to column) have no effect on any result.
- R7: `out_valid` is a single-cycle pulse. It is high exactly N·(N-1) = 56 cycles after the clock edge that accepted `in_load`.
- R8: An `in_load` pulse, or any change of `in_soft`/`in_prev_dec`, while a detection is in progress is ignored. The running detection completes with its original inputs.
- R9: Coefficient writes issued while a detection is in progress are ignored. Neither the running detection nor later ones see them.
- R10: Synchronous active-high `rst` clears the soft values, decisions, valid flag, coefficients and any detection in progress. Afterwards `out_valid`, `out_soft` and `out_dec` are zero until a new detection completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | 3 | Coefficient row (user being corrected) |
| coef_col | input | 3 | Coefficient column (interfering user) |
| coef_data | input | 12 | Signed coefficient value |
| in_load | input | 1 | Starts a detection on the present inputs when idle |
| in_soft | input | 96 | Input soft values, user k at [k*12 +: 12] |
| in_prev_dec | input | 8 | Previous stage decisions, 1 = -1 |
| out_valid | output | 1 | One-cycle strobe: outputs complete |
| out_soft | output | 96 | Refined soft values, user k at [k*12 +: 12] |
| out_dec | output | 8 | This stage's decisions, 1 = -1 |

## Verification
The bench sweeps all 256 previous-decision patterns against random soft values and coefficient sets. It compares both stage variants against an arithmetic model, so a wrong sign in the recoding would show up as doubled interference instead of removed interference. Coefficients and inputs at full scale drive the running sum past both limits. A design that wrapped would report values of the opposite sign there, and a design that saturated only the final sum would disagree on the mixed-sign cases. Further checks cover the following cases, each of which a faulty design would get visibly wrong:
- Changing only the diagonal must leave the results unchanged; a design that included the diagonal would not.
- A load or a coefficient write arriving mid-detection must leave the results unchanged; a design that accepted them would corrupt the running or the next result.
- A reset arriving mid-run must stop the run, so a design that kept a stale sequencer would raise a spurious valid.

// File: rtl/pic_stage_pkg.sv
package pic_stage_pkg;

  // Recoded difference value x = current decision - previous decision
  typedef enum logic [2:0] {
    X_ZERO = 3'd0,
    X_POS1 = 3'd1,
    X_NEG1 = 3'd2,
    X_POS2 = 3'd3,
    X_NEG2 = 3'd4
  } x_code_e;

  // Decision bits: 1 stands for -1, 0 for +1.
  function automatic x_code_e recode_x(input logic cur_neg, input logic prev_neg,
                                       input logic full_cancel);
    if (full_cancel) return cur_neg ? X_NEG1 : X_POS1;
    if (cur_neg == prev_neg) return X_ZERO;
    return cur_neg ? X_NEG2 : X_POS2;
  endfunction

  // coefficient times x, using only shift and negate
  function automatic logic signed [31:0] cancel_term(input x_code_e x,
                                                    input logic signed [31:0] c);
    case (x)
      X_POS1:  return c;
      X_NEG1:  return -c;
      X_POS2:  return c <<< 1;
      X_NEG2:  return -(c <<< 1);
      default: return 32'sd0;
    endcase
  endfunction

  // clamp a wide value into a w-bit two's-complement range
  function automatic logic signed [31:0] sat_to(input logic signed [31:0] v, input int w);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (w - 1)) - 32'sd1;
    lo = -(32'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/pic_coef_store.sv
module pic_coef_store #(
  parameter int N  = 8,
  parameter int W  = 12,
  localparam int KW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [KW-1:0]       wr_row,
  input  logic [KW-1:0]       wr_col,
  input  logic signed [W-1:0] wr_data,
  input  logic [KW-1:0]       rd_row,
  input  logic [KW-1:0]       rd_col,
  output logic signed [W-1:0] rd_data,
  output logic [N*N*W-1:0]    coef_flat
);

  logic signed [W-1:0] mem [N][N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          mem[r][c] <= '0;
    end else if (wr_en) begin
      mem[wr_row][wr_col] <= wr_data;
    end
  end

  assign rd_data = mem[rd_row][rd_col];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign coef_flat[(r*N + c)*W +: W] = mem[r][c];
    end
  end

endmodule

// File: rtl/pic_step_seq.sv
// Walks every off-diagonal (row, col) pair once, row-major, col ascending.
module pic_step_seq #(
  parameter int N  = 8,
  localparam int KW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [KW-1:0] row,
  output logic [KW-1:0] col,
  output logic          last
);

  logic [KW-1:0] m_q;

  assign col  = (m_q >= row) ? m_q + KW'(1) : m_q;
  assign last = busy && (row == KW'(N - 1)) && (m_q == KW'(N - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      row  <= '0;
      m_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        row  <= '0;
        m_q  <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else if (m_q == KW'(N - 2)) begin
      m_q <= '0;
      row <= row + KW'(1);
    end else begin
      m_q <= m_q + KW'(1);
    end
  end

endmodule

// File: rtl/pic_recoder.sv
module pic_recoder #(
  parameter bit FIRST_STAGE = 1'b0
) (
  input  logic                   cur_neg,
  input  logic                   prev_neg,
  output pic_stage_pkg::x_code_e x_code
);
  import pic_stage_pkg::*;

  if (FIRST_STAGE) begin : g_full
    assign x_code = recode_x(cur_neg, prev_neg, 1'b1);
  end else begin : g_diff
    assign x_code = recode_x(cur_neg, prev_neg, 1'b0);
  end

endmodule

// File: rtl/pic_diff_stage.sv
module pic_diff_stage #(
  parameter int N           = 8,
  parameter int W           = 12,
  parameter bit FIRST_STAGE = 1'b0,
  localparam int KW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coef_we,
  input  logic [KW-1:0]       coef_row,
  input  logic [KW-1:0]       coef_col,
  input  logic signed [W-1:0] coef_data,
  input  logic                in_load,
  input  logic [N*W-1:0]      in_soft,
  input  logic [N-1:0]        in_prev_dec,
  output logic                out_valid,
  output logic [N*W-1:0]      out_soft,
  output logic [N-1:0]        out_dec
);
  import pic_stage_pkg::*;

  logic signed [W-1:0] acc [N];
  logic [N-1:0]        dcur_q;
  logic [N-1:0]        dprev_q;

  // named internal events (observed by the bound checker)
  logic                busy;
  logic                last;
  logic                accept;
  logic                upd_fire;
  logic [KW-1:0]       upd_k;
  logic [KW-1:0]       upd_j;
  x_code_e             upd_op;
  logic signed [W-1:0] coef_rd;
  logic signed [31:0]  upd_term;
  logic signed [W-1:0] upd_old;
  logic signed [31:0]  upd_diff;
  logic signed [W-1:0] upd_new;
  logic [N*N*W-1:0]    coef_flat;

  assign accept   = in_load && !busy;
  assign upd_fire = busy;

  pic_step_seq #(.N(N)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .busy (busy),
    .row  (upd_k),
    .col  (upd_j),
    .last (last)
  );

  pic_coef_store #(.N(N), .W(W)) u_coef (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (coef_we && !busy),
    .wr_row   (coef_row),
    .wr_col   (coef_col),
    .wr_data  (coef_data),
    .rd_row   (upd_k),
    .rd_col   (upd_j),
    .rd_data  (coef_rd),
    .coef_flat(coef_flat)
  );

  pic_recoder #(.FIRST_STAGE(FIRST_STAGE)) u_rec (
    .cur_neg (dcur_q[upd_j]),
    .prev_neg(dprev_q[upd_j]),
    .x_code  (upd_op)
  );

  assign upd_term = cancel_term(upd_op, {{(32-W){coef_rd[W-1]}}, coef_rd});
  assign upd_old  = acc[upd_k];
  assign upd_diff = {{(32-W){upd_old[W-1]}}, upd_old} - upd_term;
  assign upd_new  = W'(sat_to(upd_diff, W));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) acc[i] <= '0;
      dcur_q    <= '0;
      dprev_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last;
      if (accept) begin
        for (int i = 0; i < N; i++) begin
          acc[i]    <= in_soft[i*W +: W];
          dcur_q[i] <= in_soft[i*W + W - 1];
        end
        dprev_q <= in_prev_dec;
      end else if (upd_fire) begin
        acc[upd_k] <= upd_new;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign out_soft[i*W +: W] = acc[i];
  end
  assign out_dec = dcur_q;

endmodule

// File: rtl/pic_diff_stage_chk.sv
module pic_diff_stage_chk #(
  parameter int N           = 8,
  parameter int W           = 12,
  parameter bit FIRST_STAGE = 1'b0,
  localparam int KW = (N > 1) ? $clog2(N) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_load,
  input logic                   busy,
  input logic                   accept,
  input logic                   out_valid,
  input logic [N-1:0]           out_dec,
  input logic                   upd_fire,
  input logic [KW-1:0]          upd_k,
  input logic [KW-1:0]          upd_j,
  input pic_stage_pkg::x_code_e upd_op,
  input logic signed [31:0]     upd_term,
  input logic signed [W-1:0]    upd_old,
  input logic signed [W-1:0]    upd_new,
  input logic [N*N*W-1:0]       coef_flat
);
  import pic_stage_pkg::*;

  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)         busy_cnt <= '0;
    else if (accept) busy_cnt <= '0;
    else if (busy)   busy_cnt <= busy_cnt + 16'd1;
  end

  // R4: unchanged decision leaves the accumulator untouched
  assert_skip_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && upd_op == X_ZERO) |-> (upd_new == upd_old));

  // R3: subtracting a non-negative term never raises the value (no wrap)
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_term[31]) |-> (upd_new <= upd_old));

  // R3: subtracting a non-positive term never lowers the value (no wrap)
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && (upd_term[31] || upd_term == 32'sd0)) |-> (upd_new >= upd_old));

  // R6: the diagonal is never visited
  assert_off_diag_R6: assert property (@(posedge clk) disable iff (rst)
    upd_fire |-> (upd_j != upd_k));

  // R5: the head stage always cancels in full (x = +-1)
  assert_full_cancel_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && FIRST_STAGE) |-> (upd_op == X_POS1 || upd_op == X_NEG1));

  // R7: valid is a single-cycle pulse
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7: fixed latency from acceptance
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (busy_cnt == 16'(N * (N - 1))));

  // R8: a load during a run does not recapture decisions
  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && in_load) |=> $stable(out_dec));

  // R9: coefficients are frozen while a run is in progress
  assert_coef_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(coef_flat));

endmodule

bind pic_diff_stage pic_diff_stage_chk #(.N(N), .W(W), .FIRST_STAGE(FIRST_STAGE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_load  (in_load),
  .busy     (busy),
  .accept   (accept),
  .out_valid(out_valid),
  .out_dec  (out_dec),
  .upd_fire (upd_fire),
  .upd_k    (upd_k),
  .upd_j    (upd_j),
  .upd_op   (upd_op),
  .upd_term (upd_term),
  .upd_old  (upd_old),
  .upd_new  (upd_new),
  .coef_flat(coef_flat)
);

// File: tb/tb_pic_diff_stage.sv
`timescale 1ns/1ps
module tb_pic_diff_stage;
  localparam int N  = 8;
  localparam int W  = 12;
  localparam int KW = 3;
  localparam int LAT = N * (N - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          coef_we;
  logic [KW-1:0] coef_row, coef_col;
  logic [W-1:0]  coef_data;
  logic          in_load;
  logic [N*W-1:0] in_soft;
  logic [N-1:0]  in_prev_dec;
  logic          v_d, v_f;
  logic [N*W-1:0] s_d, s_f;
  logic [N-1:0]  d_d, d_f;

  pic_diff_stage #(.N(N), .W(W), .FIRST_STAGE(1'b0)) dut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_row(coef_row), .coef_col(coef_col),
    .coef_data(coef_data), .in_load(in_load), .in_soft(in_soft), .in_prev_dec(in_prev_dec),
    .out_valid(v_d), .out_soft(s_d), .out_dec(d_d));

  pic_diff_stage #(.N(N), .W(W), .FIRST_STAGE(1'b1)) dut_first (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_row(coef_row), .coef_col(coef_col),
    .coef_data(coef_data), .in_load(in_load), .in_soft(in_soft), .in_prev_dec(in_prev_dec),
    .out_valid(v_f), .out_soft(s_f), .out_dec(d_f));

  int cm [N][N];
  int sv [N];
  logic [N-1:0] pv;
  int ez [N];
  int ezf [N];
  logic [N-1:0] ed;
  int saved [N];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampw(input int v);
    int hi = (1 <<< (W - 1)) - 1;
    int lo = -(1 <<< (W - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom_range(hi - lo, 0));
  endfunction

  function automatic int soft_of(input logic [N*W-1:0] bus, input int k);
    return int'($signed(bus[k*W +: W]));
  endfunction

  // arithmetic reference for both stage variants
  task automatic build_expect();
    for (int k = 0; k < N; k++) begin
      int z = sv[k];
      int zf = sv[k];
      ed[k] = (sv[k] < 0);
      for (int j = 0; j < N; j++) begin
        if (j != k) begin
          int dj = (sv[j] < 0) ? -1 : 1;
          int pj = pv[j] ? -1 : 1;
          z  = clampw(z - cm[k][j] * (dj - pj));
          zf = clampw(zf - cm[k][j] * dj);
        end
      end
      ez[k] = z;
      ezf[k] = zf;
    end
  endtask

  task automatic pack_inputs();
    for (int k = 0; k < N; k++) in_soft[k*W +: W] = W'(sv[k]);
    in_prev_dec = pv;
  endtask

  task automatic coef_write(input int r, input int c, input int v, input bit track);
    @(negedge clk);
    coef_we = 1'b1; coef_row = KW'(r); coef_col = KW'(c); coef_data = W'(v);
    @(negedge clk);
    coef_we = 1'b0;
    if (track) cm[r][c] = v;
  endtask

  task automatic coef_fill_random(input int lo, input int hi);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_write(r, c, rnd(lo, hi), 1'b1);
  endtask

  task automatic coef_fill_const(input int v);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_write(r, c, v, 1'b1);
  endtask

  task automatic start_run();
    @(negedge clk);
    pack_inputs();
    in_load = 1'b1;
    @(negedge clk);
    in_load = 1'b0;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    while (!v_d && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_outputs(input string tag);
    bit ok;
    int bad_a, bad_e;
    build_expect();
    ok = 1'b1; bad_a = 0; bad_e = 0;
    for (int k = 0; k < N; k++)
      if (soft_of(s_d, k) != ez[k] && ok) begin
        ok = 1'b0; bad_a = soft_of(s_d, k); bad_e = ez[k];
      end
    chk(ok, tag, "difference stage soft value", bad_a, bad_e);
    chk(d_d == ed, "R1", "decision bits", int'(d_d), int'(ed));
    ok = 1'b1; bad_a = 0; bad_e = 0;
    for (int k = 0; k < N; k++)
      if (soft_of(s_f, k) != ezf[k] && ok) begin
        ok = 1'b0; bad_a = soft_of(s_f, k); bad_e = ezf[k];
      end
    chk(ok && v_f, "R5", "first stage soft value", bad_a, bad_e);
  endtask

  task automatic run_and_check(input string tag);
    int cyc;
    start_run();
    wait_valid(cyc);
    chk(v_d == 1'b1, "R7", "valid seen", int'(v_d), 1);
    check_outputs(tag);
  endtask

  task automatic rand_soft(input int lo, input int hi);
    for (int k = 0; k < N; k++) sv[k] = rnd(lo, hi);
  endtask

  task automatic print_summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 190000);
    chk(1'b0, "R7", "watchdog expired, cycles", 190000, 0);
    print_summary();
    $finish;
  end

  initial begin
    int cyc;
    bit ok;
    rst = 1'b1; coef_we = 1'b0; coef_row = '0; coef_col = '0; coef_data = '0;
    in_load = 1'b0; in_soft = '0; in_prev_dec = '0;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cm[r][c] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(v_d == 1'b0 && v_f == 1'b0, "R10", "valid after reset", int'(v_d), 0);
    chk(s_d == '0 && s_f == '0, "R10", "soft nonzero after reset", int'(s_d != '0), 0);
    chk(d_d == '0 && d_f == '0, "R10", "decisions after reset", int'(d_d), 0);
    rst = 1'b0;

    // R7: latency and single-cycle pulse
    coef_fill_random(-300, 299);
    rand_soft(-1500, 1500); pv = N'($urandom);
    start_run();
    wait_valid(cyc);
    chk(cyc == LAT, "R7", "latency cycles", cyc, LAT);
    check_outputs("R2");
    @(negedge clk);
    chk(v_d == 1'b0 && v_f == 1'b0, "R7", "valid width", int'(v_d), 0);

    // R2: sweep of all previous-decision patterns
    for (int p = 0; p < 256; p++) begin
      if (p % 32 == 0) coef_fill_random(-400, 399);
      rand_soft(-2048, 2047);
      pv = N'(p);
      run_and_check("R2");
    end

    // R4: previous decisions equal current ones -> no change
    for (int t = 0; t < 4; t++) begin
      rand_soft(-2048, 2047);
      for (int k = 0; k < N; k++) pv[k] = (sv[k] < 0);
      run_and_check("R4");
      ok = 1'b1;
      for (int k = 0; k < N; k++) if (soft_of(s_d, k) != sv[k]) ok = 1'b0;
      chk(ok, "R4", "unchanged decisions altered soft values", int'(ok), 1);
    end

    // R3: saturation at the negative limit
    coef_fill_const(2047);
    for (int k = 0; k < N; k++) sv[k] = 2000;
    pv = '1;
    run_and_check("R3");
    chk(soft_of(s_d, 0) == -2048 && soft_of(s_d, 7) == -2048, "R3", "negative clamp",
        soft_of(s_d, 0), -2048);
    // R3: saturation at the positive limit
    coef_fill_const(-2048);
    for (int k = 0; k < N; k++) sv[k] = 100;
    pv = '1;
    run_and_check("R3");
    chk(soft_of(s_d, 3) == 2047, "R3", "positive clamp", soft_of(s_d, 3), 2047);
    // R3: mixed full-scale terms (clamping happens per term)
    for (int t = 0; t < 12; t++) begin
      if (t % 4 == 0) coef_fill_random(-2048, 2047);
      rand_soft(-2048, 2047); pv = N'($urandom);
      run_and_check("R3");
    end

    // R6: diagonal coefficients have no effect
    coef_fill_random(-500, 499);
    rand_soft(-1000, 1000); pv = N'($urandom);
    run_and_check("R6");
    for (int k = 0; k < N; k++) saved[k] = soft_of(s_d, k);
    for (int k = 0; k < N; k++) coef_write(k, k, (k % 2 == 0) ? 2047 : -2048, 1'b1);
    run_and_check("R6");
    ok = 1'b1;
    for (int k = 0; k < N; k++) if (soft_of(s_d, k) != saved[k]) ok = 1'b0;
    chk(ok, "R6", "diagonal changed the result", int'(ok), 1);

    // R8: load and input change while busy are ignored
    rand_soft(-1800, 1800); pv = N'($urandom);
    start_run();
    repeat (10) @(negedge clk);
    in_soft = ~in_soft; in_prev_dec = ~pv; in_load = 1'b1;
    @(negedge clk);
    in_load = 1'b0;
    wait_valid(cyc);
    chk(v_d == 1'b1, "R8", "valid seen", int'(v_d), 1);
    check_outputs("R8");
    @(negedge clk);
    chk(v_d == 1'b0, "R8", "second valid after ignored load", int'(v_d), 0);

    // R9: coefficient write during a run is ignored
    rand_soft(-1800, 1800); pv = N'($urandom);
    start_run();
    repeat (5) @(negedge clk);
    coef_write(1, 0, cm[1][0] + 700, 1'b0);
    wait_valid(cyc);
    check_outputs("R9");
    run_and_check("R9");

    // R10: reset in the middle of a run
    rand_soft(-1000, 1000); pv = N'($urandom);
    start_run();
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(s_d == '0 && d_d == '0, "R10", "state after mid-run reset", int'(d_d), 0);
    ok = 1'b1;
    repeat (LAT + 10) begin
      @(negedge clk);
      if (v_d || v_f) ok = 1'b0;
    end
    chk(ok, "R10", "valid after aborted run", int'(ok), 1);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cm[r][c] = 0;
    rand_soft(-1000, 1000); pv = N'($urandom);
    run_and_check("R10");
    coef_fill_random(-300, 299);
    run_and_check("R10");

    print_summary();
    $finish;
  end

endmodule